// File: doc/BRIEF.md
# Serial set-bit index summer

This block takes a wide bit vector and produces the sum of the positions of every bit that is set in it. For example, a vector with bits 3 and 5 set gives 8. The caller presents the vector together with a one-cycle load strobe. The block copies the vector into a shift register and examines one bit per clock. When the scan finishes it raises a result-valid pulse for one cycle.

The design avoids a wide multiplexer or reduction tree. The adder only ever sees three inputs: the bit shifted out of the low end of the register, the running sum, and the index counter. Bit 0 always contributes zero, so it is never stored. The result is therefore ready VEC_W-1 clocks after the load. A new load strobe abandons any scan in progress and starts over with the new vector.

Top module: `ssum_bitpos_top`

## Requirements
- R1: After synchronous reset, `sum` is 0 and `valid` is 0. A reset during a scan stops that scan, so no `valid` pulse follows.
- R2: After a load, `sum` equals the sum of the indices i for which `vec[i]` is 1, where index 0 is the least significant bit. The sum is an unsigned binary number.
- R3: `valid` is first seen high in the (VEC_W-1)-th cycle after the cycle in which `load` was high.
- R4: `valid` is high for exactly one cycle for each completed scan.
- R5: An all-ones vector gives VEC_W*(VEC_W-1)/2, which is 522753 for the default VEC_W of 1023.
- R6: An all-zeros vector gives 0. A vector with only bit 0 set also gives 0.
- R7: A load during a scan restarts the scan. No `valid` pulse belongs to the abandoned vector. The result and its timing follow the new vector and the new load only.
- R8: Changes on `vec` after the load cycle have no effect on the result.
- R9: `sum` reads 0 in the cycle after a load.
- R10: After `valid`, `sum` holds its final value until the next load.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| load | input | 1 | One-cycle strobe that captures `vec` and starts a scan |
| vec | input | VEC_W | Bit vector to be scanned |
| sum | output | clog2(VEC_W*(VEC_W-1)/2+1) | Running sum, final when `valid` |
| valid | output | 1 | One-cycle pulse when the scan completes |

## Verification
The patterns used are all-zeros, all-ones, only bit 0, only the top bit, alternating bits, and pseudo-random fills.
- The all-ones vector exercises the full sum width and the closed-form total.
- Only-bit-0 and all-zeros show that the unstored bit 0 contributes nothing.
- Only-the-top-bit shows that the last index is actually added before `valid`.
- Random fills catch index off-by-one errors.

Every scan also inverts `vec` right after the load, so any dependence on the live input shows up as a wrong sum. Directed runs cover a reload in mid-scan and a reset in mid-scan, measuring the latency and the absence of a stray pulse in each case.

// File: rtl/ssum_pkg.sv
package ssum_pkg;

   // Width of the index counter for a vector of n bits (holds n-1)
   function automatic int idx_width(input int n);
      return (n < 3) ? 1 : $clog2(n);
   endfunction

   // Width of the sum: holds n*(n-1)/2
   function automatic int sum_width(input int n);
      longint total;
      total = (longint'(n) * longint'(n - 1)) / 2;
      return (total < 2) ? 1 : $clog2(total + 1);
   endfunction

endpackage

// File: rtl/ssum_shifter.sv
module ssum_shifter #(
   parameter int VEC_W = 1023
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             load,
   input  logic             step,
   input  logic [VEC_W-1:0] vec,
   output logic             lsb
);
   localparam int REG_W = VEC_W - 1;

   logic [REG_W-1:0] shreg;
   logic             unused_bit0;

   // bit 0 always weighs zero and is never kept
   assign unused_bit0 = vec[0];

   always_ff @(posedge clk) begin
      if (rst)
         shreg <= '0;
      else if (load)
         shreg <= vec[VEC_W-1:1];
      else if (step)
         shreg <= shreg >> 1;
   end

   assign lsb = shreg[0];
endmodule

// File: rtl/ssum_sequencer.sv
module ssum_sequencer #(
   parameter int VEC_W = 1023
) (
   input  logic                                clk,
   input  logic                                rst,
   input  logic                                load,
   output logic [ssum_pkg::idx_width(VEC_W)-1:0] idx,
   output logic                                busy,
   output logic                                done
);
   localparam int CNT_W = ssum_pkg::idx_width(VEC_W);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(VEC_W - 1);

   logic [CNT_W-1:0] cnt;

   assign busy = (cnt != '0);
   assign idx  = cnt;

   always_ff @(posedge clk) begin
      if (rst) begin
         cnt  <= '0;
         done <= 1'b0;
      end else if (load) begin
         cnt  <= CNT_W'(1);
         done <= 1'b0;
      end else if (busy) begin
         if (cnt == LAST) begin
            cnt  <= '0;
            done <= 1'b1;
         end else begin
            cnt  <= cnt + CNT_W'(1);
            done <= 1'b0;
         end
      end else begin
         done <= 1'b0;
      end
   end
endmodule

// File: rtl/ssum_accum.sv
module ssum_accum #(
   parameter int VEC_W = 1023
) (
   input  logic                                clk,
   input  logic                                rst,
   input  logic                                load,
   input  logic                                step,
   input  logic                                bit_in,
   input  logic [ssum_pkg::idx_width(VEC_W)-1:0] idx,
   output logic [ssum_pkg::sum_width(VEC_W)-1:0] acc
);
   localparam int SUM_W = ssum_pkg::sum_width(VEC_W);

   always_ff @(posedge clk) begin
      if (rst)
         acc <= '0;
      else if (load)
         acc <= '0;
      else if (step && bit_in)
         acc <= acc + SUM_W'(idx);
   end
endmodule

// File: rtl/ssum_bitpos_top.sv
module ssum_bitpos_top #(
   parameter int VEC_W = 1023
) (
   input  logic                                 clk,
   input  logic                                 rst,
   input  logic                                 load,
   input  logic [VEC_W-1:0]                     vec,
   output logic [ssum_pkg::sum_width(VEC_W)-1:0] sum,
   output logic                                 valid
);
   localparam int CNT_W = ssum_pkg::idx_width(VEC_W);
   localparam int SUM_W = ssum_pkg::sum_width(VEC_W);

   generate
      if (VEC_W < 2) begin : g_bad_width
         $error("ssum_bitpos_top: VEC_W must be at least 2");
      end
      if ((1 << CNT_W) <= (VEC_W - 1)) begin : g_bad_cnt
         $error("ssum_bitpos_top: index counter too narrow");
      end
   endgenerate

   logic             busy;
   logic             lsb;
   logic [CNT_W-1:0] idx;
   logic [SUM_W-1:0] acc;

   ssum_sequencer #(.VEC_W(VEC_W)) u_seq (
      .clk  (clk),
      .rst  (rst),
      .load (load),
      .idx  (idx),
      .busy (busy),
      .done (valid)
   );

   ssum_shifter #(.VEC_W(VEC_W)) u_shift (
      .clk  (clk),
      .rst  (rst),
      .load (load),
      .step (busy),
      .vec  (vec),
      .lsb  (lsb)
   );

   ssum_accum #(.VEC_W(VEC_W)) u_acc (
      .clk    (clk),
      .rst    (rst),
      .load   (load),
      .step   (busy),
      .bit_in (lsb),
      .idx    (idx),
      .acc    (acc)
   );

   assign sum = acc;
endmodule

// File: rtl/ssum_bitpos_chk.sv
module ssum_bitpos_chk #(
   parameter int VEC_W = 1023
) (
   input logic                                 clk,
   input logic                                 rst,
   input logic                                 load,
   input logic [ssum_pkg::sum_width(VEC_W)-1:0] sum,
   input logic                                 valid
);
   localparam int AGE_W = ssum_pkg::idx_width(VEC_W) + 2;
   localparam logic [AGE_W-1:0] AGE_MAX = '1;

   logic [AGE_W-1:0] age;
   logic             held;

   always_ff @(posedge clk) begin
      if (rst) begin
         age  <= '0;
         held <= 1'b0;
      end else begin
         if (load)
            age <= AGE_W'(1);
         else if (age != '0 && age != AGE_MAX)
            age <= age + AGE_W'(1);
         if (load)
            held <= 1'b0;
         else if (valid)
            held <= 1'b1;
      end
   end

   // R3
   valid_latency_chk: assert property (@(posedge clk) disable iff (rst)
      valid |-> (age == AGE_W'(VEC_W)));

   // R4
   valid_pulse_chk: assert property (@(posedge clk) disable iff (rst)
      valid |=> !valid);

   // R7
   reload_quiet_chk: assert property (@(posedge clk) disable iff (rst)
      load |=> !valid);

   // R9
   sum_clear_chk: assert property (@(posedge clk) disable iff (rst)
      load |=> (sum == '0));

   // R10
   sum_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (held && !load) |=> $stable(sum));
endmodule

bind ssum_bitpos_top ssum_bitpos_chk #(.VEC_W(VEC_W)) u_chk (
   .clk   (clk),
   .rst   (rst),
   .load  (load),
   .sum   (sum),
   .valid (valid)
);

// File: tb/ssum_bitpos_top_test.sv
module ssum_bitpos_top_test;
   localparam int N     = 1023;
   localparam int SUM_W = ssum_pkg::sum_width(N);
   localparam int NPAT  = 8;
   // kind: 0 zeros, 1 ones, 2 random, 3 only bit 0, 4 only top bit, 5 alternating
   localparam int PAT_KIND [NPAT] = '{0, 1, 2, 3, 4, 5, 2, 2};
   localparam int PAT_SEED [NPAT] = '{0, 0, 32'h1234_5677, 0, 0, 0, 32'h0BAD_F00D, 32'h7357_0001};

   logic             clk = 1'b0;
   logic             rst = 1'b1;
   logic             load = 1'b0;
   logic [N-1:0]     vec = '0;
   logic [SUM_W-1:0] sum;
   logic             valid;

   int n_chk  = 0;
   int n_fail = 0;

   ssum_bitpos_top #(.VEC_W(N)) uut (
      .clk(clk), .rst(rst), .load(load), .vec(vec), .sum(sum), .valid(valid)
   );

   always #10 clk = ~clk;

   task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   function automatic logic [N-1:0] make_vec(input int kind, input int seed);
      logic [N-1:0] v;
      logic [31:0]  s;
      v = '0;
      s = (seed == 0) ? 32'h1 : seed;
      for (int i = 0; i < N; i++) begin
         case (kind)
            1: v[i] = 1'b1;
            2: begin
               s = s ^ (s << 13);
               s = s ^ (s >> 17);
               s = s ^ (s << 5);
               v[i] = s[7];
            end
            3: v[i] = (i == 0);
            4: v[i] = (i == N - 1);
            5: v[i] = i[0];
            default: v[i] = 1'b0;
         endcase
      end
      return v;
   endfunction

   function automatic longint ref_sum(input logic [N-1:0] v);
      longint t;
      t = 0;
      for (int i = 0; i < N; i++)
         if (v[i]) t += i;
      return t;
   endfunction

   // strobe load for one cycle; returns at the negedge after the load edge
   task automatic do_load(input logic [N-1:0] v);
      @(negedge clk);
      vec  = v;
      load = 1'b1;
      @(posedge clk);
      @(negedge clk);
      load = 1'b0;
   endtask

   // wait for valid; returns cycle count after the load edge (0 if none)
   task automatic wait_valid(input int limit, output int at);
      at = 0;
      for (int k = 1; k <= limit; k++) begin
         @(posedge clk);
         @(negedge clk);
         if (valid) begin
            at = k;
            return;
         end
      end
   endtask

   task automatic run_scan(input logic [N-1:0] v, input string tag);
      longint exp;
      int     at;
      exp = ref_sum(v);
      do_load(v);
      chk(sum == 0, {"R9 cleared ", tag}, sum, 0);
      vec = ~v; // R8: live input changes must not matter
      wait_valid(N + 10, at);
      chk(at == N - 1, {"R3 latency ", tag}, at, N - 1);
      chk(sum == exp, {"R2 R8 value ", tag}, sum, exp);
      @(posedge clk);
      @(negedge clk);
      chk(valid == 1'b0, {"R4 pulse ", tag}, valid, 0);
      for (int k = 0; k < 20; k++) begin
         @(posedge clk);
         @(negedge clk);
      end
      chk(sum == exp, {"R10 hold ", tag}, sum, exp);
   endtask

   initial begin
      #2_000_000;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
   end

   initial begin
      logic [N-1:0] v;
      int at;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      chk(sum == 0, "R1 reset sum", sum, 0);
      chk(valid == 0, "R1 reset valid", valid, 0);

      for (int p = 0; p < NPAT; p++) begin
         v = make_vec(PAT_KIND[p], PAT_SEED[p]);
         run_scan(v, $sformatf("pattern %0d", p));
         if (PAT_KIND[p] == 1) begin
            chk(sum == longint'(N) * (N - 1) / 2, "R5 all ones", sum, longint'(N) * (N - 1) / 2);
            if (N == 1023) chk(sum == 522753, "R5 all ones literal", sum, 522753);
         end
         if (PAT_KIND[p] == 0) chk(sum == 0, "R6 zeros", sum, 0);
         if (PAT_KIND[p] == 3) chk(sum == 0, "R6 only bit0", sum, 0);
      end

      // R7: reload in mid-scan
      do_load(make_vec(1, 0));
      for (int k = 0; k < 300; k++) @(negedge clk);
      chk(valid == 0, "R7 no early valid", valid, 0);
      v = make_vec(2, 32'h00C0_FFEE);
      do_load(v);
      wait_valid(N + 10, at);
      chk(at == N - 1, "R7 restart latency", at, N - 1);
      chk(sum == ref_sum(v), "R7 restart value", sum, ref_sum(v));

      // R1: reset in mid-scan stops the scan
      do_load(make_vec(1, 0));
      for (int k = 0; k < 100; k++) @(negedge clk);
      rst = 1'b1;
      @(negedge clk);
      rst = 1'b0;
      chk(sum == 0, "R1 mid-scan reset sum", sum, 0);
      wait_valid(N + 10, at);
      chk(at == 0, "R1 no valid after reset", at, 0);

      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
   end
endmodule